// File: doc/BRIEF.md
# ADC Group Conversion Sequencer

This block steps an analog-to-digital converter through two programmed channel lists. The regular list is for background conversions. The inserted list is for conversions that must go first. Each list has its own length, a software start bit and an external trigger input with its own enable. Each list also has an end-of-pass flag, and each flag has an interrupt enable. Toward the converter the block issues a one-cycle start pulse with a channel number. It then waits for a done pulse that carries the result. Regular results land in one data register. Inserted results land in one data register per slot.

The block has three ways to run a list. In scan mode it walks the whole list. In continuous mode the regular list repeats without new triggers. In discontinuous mode each trigger converts part of a list: the regular list converts a sub-run of n channels and resumes where it stopped, and the inserted list converts one channel. The only way into the block is a flat register port with a write strobe and a combinational read.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, start_o and irq_o are 0, the status register (address 2) reads 0 and the regular data register (address 5) reads 0.
- R2: Writing 1 to bit 0 (regular) or bit 1 (inserted) of the start register (address 2'h1) with the engine idle gives start_o = 1 in the very next cycle. The start register always reads 0.
- R3: With scan (control bit 0) set, a regular run converts the channels in slots 0 up to the programmed length register (address 3, value = length - 1) in slot order. With scan clear, a run converts only slot 0. Regular slot k is at address 8+k.
- R4: With continuous (control bit 1) set, a regular run wraps from the last slot to slot 0 with no new trigger. Clearing continuous ends the run at the end of the current pass.
- R5: With regular discontinuous (control bit 2) set, each trigger converts the next n = field[6:4] + 1 regular slots. The next trigger resumes from the saved position.
- R6: When a discontinuous sub-run reaches the last regular slot before n conversions are done, it stops there, sets the regular end flag and wraps the position to slot 0.
- R7: The regular end flag (status bit 0) is set only when the last slot of the regular list completes. Each regular result is written to the regular data register.
- R8: An inserted run in scan mode converts inserted slots 0 up to the inserted length (address 4, value = length - 1). Inserted slot k is at address 16+k. The result of slot k appears at address 24+k. The inserted end flag (status bit 1) is set at the end of the pass.
- R9: With inserted discontinuous (control bit 3) set, each trigger converts exactly one inserted slot. The inserted end flag is set only by the conversion of the last slot.
- R10: A control write with both discontinuous bits set keeps the regular one and forces the inserted one to 0.
- R11: Writing 0 to a status bit clears it and writing 1 leaves it unchanged. irq_o is high while status bit 0 is set with enable bit 7, or while status bit 1 is set with enable bit 8.
- R12: A trigger that arrives while a group's run is active is held and starts a new run later. An external trigger (regular enable bit 9, inserted enable bit 10) is ignored while its enable is clear.
- R13: When both groups want the converter, the inserted group takes the next conversion. A regular run that was in progress then resumes.
- R14: start_o lasts exactly one cycle, and chan_o holds its value until the conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational on addr_i) |
| reg_ext_i | input | 1 | External trigger, regular group |
| ins_ext_i | input | 1 | External trigger, inserted group |
| start_o | output | 1 | Conversion start pulse to the converter |
| chan_o | output | CH_W | Channel for the conversion being started |
| done_i | input | 1 | Conversion complete pulse from the converter |
| result_i | input | DATA_W | Conversion result, valid with done_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with 8 regular slots, 4 inserted slots, 5-bit channels and 12-bit results. Eight regular slots allow a full n = 8 sub-run and also a clipped sub-run against a shorter list. They also allow a resumed sub-run that ends exactly at the list end. Four inserted slots allow a three-slot inserted pass, stepped one trigger at a time in discontinuous mode. A converter model with a fixed delay leaves a window in which second triggers, external pulses and inserted requests arrive mid-conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int ADDR_W = 5;
  localparam int REG_W  = 32;
  localparam int DCNT_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 5'd0;
  localparam logic [ADDR_W-1:0] A_START = 5'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 5'd2;
  localparam logic [ADDR_W-1:0] A_RLEN  = 5'd3;
  localparam logic [ADDR_W-1:0] A_ILEN  = 5'd4;
  localparam logic [ADDR_W-1:0] A_RDATA = 5'd5;

  // address page = addr[4:3]
  localparam logic [1:0] PG_MISC  = 2'b00;
  localparam logic [1:0] PG_RSLOT = 2'b01;
  localparam logic [1:0] PG_ISLOT = 2'b10;
  localparam logic [1:0] PG_IDATA = 2'b11;

  typedef enum logic {GRP_REG = 1'b0, GRP_INS = 1'b1} grp_e;
endpackage

// File: rtl/adc_seq_pend.sv
module adc_seq_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic take_i,
  output logic req_o
);
  logic pend_q;

  assign req_o = pend_q | trig_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q | trig_i) & ~take_i;
  end
endmodule

// File: rtl/adc_seq_slot_list.sv
module adc_seq_slot_list #(
  parameter int SLOTS = 8,
  parameter int CH_W  = 5,
  localparam int PW   = $clog2(SLOTS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [PW-1:0]   cidx_i,
  input  logic [CH_W-1:0] wch_i,
  output logic [CH_W-1:0] cch_o,
  input  logic [PW-1:0]   ridx_i,
  output logic [CH_W-1:0] rch_o
);
  logic [CH_W-1:0] ch_q [SLOTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SLOTS; i++) ch_q[i] <= '0;
    end else if (we_i) begin
      ch_q[cidx_i] <= wch_i;
    end
  end

  assign cch_o = ch_q[cidx_i];
  assign rch_o = ch_q[ridx_i];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int REG_SLOTS = 8,
  parameter int INS_SLOTS = 4,
  parameter int CH_W      = 5,
  parameter int DATA_W    = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [4:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              reg_ext_i,
  input  logic              ins_ext_i,
  output logic              start_o,
  output logic [CH_W-1:0]   chan_o,
  input  logic              done_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              irq_o
);
  localparam int RPW = $clog2(REG_SLOTS);
  localparam int IPW = $clog2(INS_SLOTS);

  // configuration and status
  logic scan_q, cont_q, rdisc_q, idisc_q, eoc_ie_q, eoic_ie_q, rext_q, iext_q;
  logic [DCNT_W-1:0] dcnt_q;
  logic [RPW-1:0]    rlen_q;
  logic [IPW-1:0]    ilen_q;
  logic              eoc_q, eoic_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] idata_q [INS_SLOTS];

  // engine
  logic              busy_q, start_q, reg_run_q, ins_run_q;
  grp_e              grp_q;
  logic [CH_W-1:0]   chan_q;
  logic [RPW-1:0]    reg_pos_q;
  logic [IPW-1:0]    ins_pos_q;
  logic [DCNT_W:0]   reg_left_q;

  logic [1:0] page;
  logic wr_ctrl, wr_stat, sw_reg, sw_ins, reg_trig, ins_trig;
  logic reg_req, ins_req, ins_want, reg_want;
  logic launch_ins, launch_reg, take_ins, take_reg, done_ev;
  logic reg_last, ins_last, eoc_set, eoic_set;
  logic [RPW-1:0] reg_idx;
  logic [IPW-1:0] ins_idx;
  logic [CH_W-1:0] reg_ch, ins_ch, rcfg_ch, icfg_ch;
  logic unused_wdata;

  assign page    = addr_i[4:3];
  assign wr_ctrl = we_i && addr_i == A_CTRL;
  assign wr_stat = we_i && addr_i == A_STAT;
  assign sw_reg  = we_i && addr_i == A_START && wdata_i[0];
  assign sw_ins  = we_i && addr_i == A_START && wdata_i[1];
  assign reg_trig = sw_reg | (rext_q & reg_ext_i);
  assign ins_trig = sw_ins | (iext_q & ins_ext_i);
  assign unused_wdata = ^wdata_i[31:11];

  adc_seq_pend u_reg_pend (.clk_i, .rst_ni, .trig_i(reg_trig), .take_i(take_reg), .req_o(reg_req));
  adc_seq_pend u_ins_pend (.clk_i, .rst_ni, .trig_i(ins_trig), .take_i(take_ins), .req_o(ins_req));

  adc_seq_slot_list #(.SLOTS(REG_SLOTS), .CH_W(CH_W)) u_reg_list (
    .clk_i, .rst_ni,
    .we_i(we_i && page == PG_RSLOT), .cidx_i(addr_i[RPW-1:0]), .wch_i(wdata_i[CH_W-1:0]),
    .cch_o(rcfg_ch), .ridx_i(reg_idx), .rch_o(reg_ch));

  adc_seq_slot_list #(.SLOTS(INS_SLOTS), .CH_W(CH_W)) u_ins_list (
    .clk_i, .rst_ni,
    .we_i(we_i && page == PG_ISLOT), .cidx_i(addr_i[IPW-1:0]), .wch_i(wdata_i[CH_W-1:0]),
    .cch_o(icfg_ch), .ridx_i(ins_idx), .rch_o(ins_ch));

  // scan off: slot 0 only
  assign reg_idx  = scan_q ? reg_pos_q : '0;
  assign ins_idx  = scan_q ? ins_pos_q : '0;
  assign reg_last = !scan_q || reg_pos_q == rlen_q;
  assign ins_last = !scan_q || ins_pos_q == ilen_q;

  // inserted group wins arbitration between conversions
  assign ins_want   = ins_run_q | ins_req;
  assign reg_want   = reg_run_q | reg_req;
  assign launch_ins = !busy_q && ins_want;
  assign launch_reg = !busy_q && !ins_want && reg_want;
  assign take_ins   = launch_ins && !ins_run_q;
  assign take_reg   = launch_reg && !reg_run_q;
  assign done_ev    = busy_q && done_i;
  assign eoc_set    = done_ev && grp_q == GRP_REG && reg_last;
  assign eoic_set   = done_ev && grp_q == GRP_INS && ins_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {scan_q, cont_q, rdisc_q, idisc_q, eoc_ie_q, eoic_ie_q, rext_q, iext_q} <= '0;
      dcnt_q <= '0;
      rlen_q <= '0;
      ilen_q <= '0;
      eoc_q  <= 1'b0;
      eoic_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        scan_q    <= wdata_i[0];
        cont_q    <= wdata_i[1];
        rdisc_q   <= wdata_i[2];
        idisc_q   <= wdata_i[3] & ~wdata_i[2];
        dcnt_q    <= wdata_i[6:4];
        eoc_ie_q  <= wdata_i[7];
        eoic_ie_q <= wdata_i[8];
        rext_q    <= wdata_i[9];
        iext_q    <= wdata_i[10];
      end
      if (we_i && addr_i == A_RLEN) rlen_q <= wdata_i[RPW-1:0];
      if (we_i && addr_i == A_ILEN) ilen_q <= wdata_i[IPW-1:0];
      // set beats a same-cycle clear
      eoc_q  <= eoc_set  || (eoc_q  && !(wr_stat && !wdata_i[0]));
      eoic_q <= eoic_set || (eoic_q && !(wr_stat && !wdata_i[1]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      start_q    <= 1'b0;
      grp_q      <= GRP_REG;
      chan_q     <= '0;
      reg_run_q  <= 1'b0;
      ins_run_q  <= 1'b0;
      reg_pos_q  <= '0;
      ins_pos_q  <= '0;
      reg_left_q <= '0;
      rdata_q    <= '0;
      for (int i = 0; i < INS_SLOTS; i++) idata_q[i] <= '0;
    end else begin
      start_q <= 1'b0;
      if (launch_ins || launch_reg) begin
        busy_q  <= 1'b1;
        start_q <= 1'b1;
        grp_q   <= launch_ins ? GRP_INS : GRP_REG;
        chan_q  <= launch_ins ? ins_ch : reg_ch;
      end
      if (take_reg) begin
        reg_run_q  <= 1'b1;
        reg_left_q <= {1'b0, dcnt_q} + 1'b1;
      end
      if (take_ins) ins_run_q <= 1'b1;
      if (done_ev) begin
        busy_q <= 1'b0;
        if (grp_q == GRP_REG) begin
          rdata_q   <= result_i;
          reg_pos_q <= reg_last ? '0 : reg_pos_q + 1'b1;
          if (rdisc_q) begin
            reg_left_q <= reg_left_q - 1'b1;
            reg_run_q  <= !(reg_last || reg_left_q == 1);
          end else begin
            reg_run_q  <= !reg_last || cont_q;
          end
        end else begin
          idata_q[ins_idx] <= result_i;
          ins_pos_q <= ins_last ? '0 : ins_pos_q + 1'b1;
          ins_run_q <= !idisc_q && !ins_last;
        end
      end
    end
  end

  assign start_o = start_q;
  assign chan_o  = chan_q;
  assign irq_o   = (eoc_q && eoc_ie_q) || (eoic_q && eoic_ie_q);

  always_comb begin
    rdata_o = '0;
    unique case (page)
      PG_MISC: begin
        case (addr_i)
          A_CTRL:  rdata_o = {21'b0, iext_q, rext_q, eoic_ie_q, eoc_ie_q, dcnt_q,
                              idisc_q, rdisc_q, cont_q, scan_q};
          A_STAT:  rdata_o = {30'b0, eoic_q, eoc_q};
          A_RLEN:  rdata_o = REG_W'(rlen_q);
          A_ILEN:  rdata_o = REG_W'(ilen_q);
          A_RDATA: rdata_o = REG_W'(rdata_q);
          default: rdata_o = '0;
        endcase
      end
      PG_RSLOT: rdata_o = REG_W'(rcfg_ch);
      PG_ISLOT: rdata_o = REG_W'(icfg_ch);
      PG_IDATA: rdata_o = REG_W'(idata_q[addr_i[IPW-1:0]]);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            we_i,
  input logic [4:0]      addr_i,
  input logic [31:0]     wdata_i,
  input logic            done_i,
  input logic            start_o,
  input logic [CH_W-1:0] chan_o,
  input logic            irq_o,
  input logic            busy_q,
  input logic            eoc_q,
  input logic            eoic_q,
  input logic            rdisc_q,
  input logic            idisc_q
);
  assert_disc_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rdisc_q && idisc_q));

  assert_sw_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_START && wdata_i[0] && !busy_q) |=> start_o);

  assert_start_pulse_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  assert_chan_hold_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_o) |-> $stable(chan_o));

  assert_irq_source_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (eoc_q || eoic_q));

  assert_eoc_on_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eoc_q) |-> $past(done_i));
endmodule

bind adc_seq_ctrl adc_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .done_i(done_i), .start_o(start_o), .chan_o(chan_o), .irq_o(irq_o),
  .busy_q(busy_q), .eoc_q(eoc_q), .eoic_q(eoic_q), .rdisc_q(rdisc_q), .idisc_q(idisc_q));

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        reg_ext_i = 1'b0, ins_ext_i = 1'b0;
  logic        start_o, done_i = 1'b0, irq_o;
  logic [4:0]  chan_o;
  logic [11:0] result_i = '0;

  int n_chk = 0, n_fail = 0, n_conv = 0;
  logic [4:0] log_ch [1024];

  always #2.5 clk_i = ~clk_i;

  adc_seq_ctrl dut_i (.*);

  function automatic logic [11:0] conv_val(input logic [4:0] ch);
    return 12'(ch * 100 + 7);
  endfunction

  // converter model: done three cycles after the start pulse
  initial begin
    forever begin
      @(negedge clk_i);
      if (start_o) begin
        logic [4:0] ch;
        ch = chan_o;
        log_ch[n_conv % 1024] = ch;
        n_conv++;
        repeat (3) @(negedge clk_i);
        done_i = 1'b1;
        result_i = conv_val(ch);
        @(negedge clk_i);
        done_i = 1'b0;
      end
    end
  end

  typedef struct packed {
    logic [10:0] ctrl;
    logic [2:0]  rlen;
    logic [3:0]  n;
    logic [4:0]  last;
    logic        eoc;
  } vec_t;

  // regular slot k holds channel k+3
  localparam vec_t VECS [7] = '{
    '{11'h001, 3'd3, 4'd4, 5'd6,  1'b1},
    '{11'h001, 3'd0, 4'd1, 5'd3,  1'b1},
    '{11'h000, 3'd3, 4'd1, 5'd3,  1'b1},
    '{11'h015, 3'd3, 4'd2, 5'd4,  1'b0},
    '{11'h075, 3'd2, 4'd3, 5'd5,  1'b1},
    '{11'h005, 3'd7, 4'd1, 5'd3,  1'b0},
    '{11'h001, 3'd7, 4'd8, 5'd10, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic settle();
    int quiet = 0;
    while (quiet < 12) begin
      @(negedge clk_i);
      quiet = start_o ? 0 : quiet + 1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int k = 0; k < 8; k++) wr(5'(8 + k), 32'(k + 3));
    for (int k = 0; k < 4; k++) wr(5'(16 + k), 32'(20 + k));
  endtask

  function automatic logic [4:0] lg(input int idx);
    return log_ch[idx % 1024];
  endfunction

  initial begin
    logic [31:0] d;
    int base;
    int seen_ins;

    // R1 reset state
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1 start_o", 32'(start_o), 0);
    chk("R1 irq_o", 32'(irq_o), 0);
    rd(A_STAT_ADDR(), d); chk("R1 status", d, 0);
    rd(5'd5, d); chk("R1 rdata", d, 0);

    // vector table: R3 R5 R6 R7
    for (int i = 0; i < 7; i++) begin
      do_reset();
      wr(5'd3, 32'(VECS[i].rlen));
      wr(5'd0, {21'b0, VECS[i].ctrl});
      base = n_conv;
      wr(5'd1, 32'd1);
      settle();
      chk($sformatf("R3/R5 vec%0d count", i), 32'(n_conv - base), 32'(VECS[i].n));
      chk($sformatf("R3/R6 vec%0d last ch", i), 32'(lg(n_conv - 1)), 32'(VECS[i].last));
      rd(5'd2, d); chk($sformatf("R6/R7 vec%0d eoc", i), 32'(d[0]), 32'(VECS[i].eoc));
      rd(5'd5, d); chk($sformatf("R7 vec%0d rdata", i), d, 32'(conv_val(VECS[i].last)));
    end

    // R2 start timing, R14 single-cycle start
    do_reset();
    wr(5'd0, 32'h001);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = 5'd1; wdata_i = 32'd1;
    @(negedge clk_i);
    we_i = 1'b0;
    chk("R2 start next cycle", 32'(start_o), 1);
    chk("R2 chan slot0", 32'(chan_o), 3);
    @(negedge clk_i);
    chk("R14 start one cycle", 32'(start_o), 0);
    rd(5'd1, d); chk("R2 start reads 0", d, 0);
    settle();

    // R5 resume across triggers, R6 wrap
    do_reset();
    wr(5'd3, 32'd4);
    wr(5'd0, 32'h025);
    base = n_conv; wr(5'd1, 1); settle();
    chk("R5 sub-run 1 count", 32'(n_conv - base), 3);
    chk("R5 sub-run 1 last", 32'(lg(n_conv - 1)), 5);
    rd(5'd2, d); chk("R5 no eoc mid-list", 32'(d[0]), 0);
    base = n_conv; wr(5'd1, 1); settle();
    chk("R6 clipped count", 32'(n_conv - base), 2);
    chk("R6 clipped last", 32'(lg(n_conv - 1)), 7);
    rd(5'd2, d); chk("R6 eoc at list end", 32'(d[0]), 1);
    base = n_conv; wr(5'd1, 1); settle();
    chk("R6 wrapped to slot0", 32'(lg(base)), 3);

    // R4 continuous
    do_reset();
    wr(5'd3, 32'd1);
    wr(5'd0, 32'h003);
    base = n_conv; wr(5'd1, 1);
    repeat (40) @(negedge clk_i);
    chk("R4 enough convs", 32'(n_conv - base >= 5), 1);
    for (int k = 0; k < 5; k++)
      chk($sformatf("R4 cont slot%0d", k), 32'(lg(base + k)), (k % 2 == 0) ? 3 : 4);
    wr(5'd0, 32'h001);
    settle();
    chk("R4 stops at pass end", 32'(lg(n_conv - 1)), 4);

    // R8 inserted scan, per-slot data, irq
    do_reset();
    wr(5'd4, 32'd2);
    wr(5'd0, 32'h101);
    base = n_conv; wr(5'd1, 32'd2); settle();
    chk("R8 ins count", 32'(n_conv - base), 3);
    for (int k = 0; k < 3; k++) begin
      chk($sformatf("R8 ins ch%0d", k), 32'(lg(base + k)), 32'(20 + k));
      rd(5'(24 + k), d); chk($sformatf("R8 idata%0d", k), d, 32'(conv_val(5'(20 + k))));
    end
    rd(5'd2, d); chk("R8 eoic", d, 32'h2);
    chk("R11 irq eoic", 32'(irq_o), 1);

    // R11 write-0 clear
    wr(5'd2, 32'h3);
    rd(5'd2, d); chk("R11 write 1 keeps", d, 32'h2);
    wr(5'd2, 32'h0);
    rd(5'd2, d); chk("R11 write 0 clears", d, 0);
    chk("R11 irq drops", 32'(irq_o), 0);

    // R9 inserted discontinuous
    do_reset();
    wr(5'd4, 32'd2);
    wr(5'd0, 32'h009);
    for (int k = 0; k < 3; k++) begin
      base = n_conv; wr(5'd1, 32'd2); settle();
      chk($sformatf("R9 one per trig %0d", k), 32'(n_conv - base), 1);
      chk($sformatf("R9 ch %0d", k), 32'(lg(base)), 32'(20 + k));
      rd(5'd2, d); chk($sformatf("R9 eoic %0d", k), 32'(d[1]), (k == 2) ? 1 : 0);
    end

    // R10 exclusion
    wr(5'd0, 32'h00D);
    rd(5'd0, d); chk("R10 ins disc forced off", d, 32'h005);

    // R12 external trigger gating and pending
    do_reset();
    wr(5'd0, 32'h001);
    base = n_conv;
    @(negedge clk_i); reg_ext_i = 1'b1; @(negedge clk_i); reg_ext_i = 1'b0;
    settle();
    chk("R12 ext ignored", 32'(n_conv - base), 0);
    wr(5'd0, 32'h201);
    @(negedge clk_i); reg_ext_i = 1'b1; @(negedge clk_i); reg_ext_i = 1'b0;
    settle();
    chk("R12 ext enabled", 32'(n_conv - base), 1);
    wr(5'd3, 32'd3);
    wr(5'd0, 32'h005);
    base = n_conv;
    wr(5'd1, 1);
    wr(5'd1, 1);
    settle();
    chk("R12 pending count", 32'(n_conv - base), 2);
    chk("R12 pending second ch", 32'(lg(base + 1)), 4);

    // R13 inserted priority over running regular
    do_reset();
    wr(5'd3, 32'd1);
    wr(5'd4, 32'd0);
    wr(5'd0, 32'h003);
    wr(5'd1, 1);
    repeat (15) @(negedge clk_i);
    base = n_conv;
    wr(5'd1, 32'd2);
    repeat (30) @(negedge clk_i);
    seen_ins = (lg(base) == 5'd20) ? 1 : 0;
    chk("R13 inserted next", 32'(seen_ins), 1);
    chk("R13 regular resumes", 32'(lg(base + 1) == 5'd3 || lg(base + 1) == 5'd4), 1);
    wr(5'd0, 32'h001);
    settle();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  function automatic logic [4:0] A_STAT_ADDR();
    return 5'd2;
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule